// File: doc/BRIEF.md
# Flash Erase Sequencer with Toggle Polling

This block sits on the host side of a parallel NOR flash bus. A one-cycle request starts a whole-chip erase. The block writes the six-cycle erase command to the flash. It then reads the flash status word over and over until the erase has finished or failed, and it reports the outcome with a single-cycle done or error pulse.

An erase has finished when status bit 6 holds the same value on two reads in a row, or when status bit 7 reads 1. If bit 5 is set while bit 6 is still changing, the block reads the status once more. If bit 6 changes again on that read, the erase has failed. After a failure the block writes the reset command, which returns the flash to array read, and only then raises the error pulse.

A second request type reads the flash identifier. It returns the manufacturer code and the device code on two holding outputs.

Each bus write holds write-enable low for a fixed, parameterized number of clocks. Each bus read holds output-enable low for its own fixed count. One idle clock separates any two bus cycles.

Top module: `nor_erase_seq`

## Requirements
- R1: After reset, fl_we_n and fl_oe_n are 1, and busy, done and error are 0.
- R2: An erase request produces six bus writes with 11-bit address and 8-bit data, in this order: (555h,AAh), (2AAh,55h), (555h,80h), (555h,AAh), (2AAh,55h), (555h,10h).
- R3: Every bus write holds fl_we_n low for exactly WE_CYC clocks, and fl_we_n and fl_oe_n are never low at the same time.
- R4: After the erase command, the block reads address 0 repeatedly. When DQ[6] has the same value on two consecutive reads, the block pulses done and makes no further bus cycles.
- R5: A status read with DQ[7]=1 ends polling with a done pulse, even on the first read.
- R6: DQ[5]=1 on a read whose DQ[6] differs from the previous read triggers exactly one more read. If DQ[6] differs again on that read, the erase has failed; if it matches, done is pulsed. DQ[5] is ignored on the first read and on a read whose DQ[6] is stable.
- R7: On failure, the block writes F0h to address 0 and then pulses error without done. The next request runs normally.
- R8: An identifier request writes (555h,AAh), (2AAh,55h), (555h,90h). It then reads address 0 into id_mfr and address 1 into id_dev, writes F0h to address 0, and pulses done.
- R9: done and error each last one cycle and never occur together. While busy is 0, no bus cycle is active.
- R10: A request that arrives while busy is 1 is ignored. If erase_req and id_req are both high in an idle cycle, the erase runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| erase_req | input | 1 | Start a chip erase |
| id_req | input | 1 | Start an identifier read |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: operation finished successfully |
| error | output | 1 | One-cycle pulse: erase failed and the flash has been reset |
| id_mfr | output | DW | Manufacturer code from the last identifier read |
| id_dev | output | DW | Device code from the last identifier read |
| fl_addr | output | AW | Flash address |
| fl_dout | output | DW | Data driven to the flash during writes |
| fl_din | input | DW | Data returned by the flash during reads |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |

## Verification
The hardest case to reach is the race in which DQ[5] rises on the very read where DQ[6] changes for the last time. A correct design must then re-read the status and report success, not failure.

The bench flash model builds each status word from a per-run script. The script sets the read on which toggling stops, the read from which DQ[5] is held, and whether DQ[7] ends the run. One vector places the DQ[5] read on the final toggle. Other vectors cover a stable read with DQ[5] set, DQ[5] on the first read, and a genuine timeout.

// File: rtl/nor_erase_seq.sv
module nor_erase_seq #(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int WE_CYC = 3,
  parameter int RD_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          erase_req,
  input  logic          id_req,
  output logic          busy,
  output logic          done,
  output logic          error,
  output logic [DW-1:0] id_mfr,
  output logic [DW-1:0] id_dev,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dout,
  input  logic [DW-1:0] fl_din,
  output logic          fl_we_n,
  output logic          fl_oe_n
);
  localparam int MAXC = (WE_CYC > RD_CYC) ? WE_CYC : RD_CYC;
  localparam int CW = $clog2(MAXC + 1);

  typedef enum logic [1:0] {S_IDLE, S_WR, S_RD, S_GAP} st_t;
  typedef enum logic [1:0] {P_CMD, P_POLL, P_IDRD, P_RST} ph_t;
  typedef enum logic [1:0] {V_CONT, V_DONE, V_FAIL} vd_t;

  st_t st;
  ph_t ph;
  vd_t vd;
  logic [CW-1:0] cnt;
  logic [2:0] idx, lk;
  logic is_id, lk_id, first, recheck, prev6, last_cmd;
  logic [10:0] c_addr;
  logic [7:0] c_data;

  assign busy = (st != S_IDLE);
  assign lk = (st == S_IDLE) ? 3'd0 : idx + 3'd1;
  assign lk_id = (st == S_IDLE) ? !erase_req : is_id;
  assign last_cmd = is_id ? (idx == 3'd2) : (idx == 3'd5);

  always_comb begin
    case (lk)
      3'd0, 3'd3: begin c_addr = 11'h555; c_data = 8'hAA; end
      3'd1, 3'd4: begin c_addr = 11'h2AA; c_data = 8'h55; end
      3'd2:       begin c_addr = 11'h555; c_data = lk_id ? 8'h90 : 8'h80; end
      default:    begin c_addr = 11'h555; c_data = 8'h10; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= P_CMD; vd <= V_CONT;
      cnt <= '0; idx <= '0; is_id <= 1'b0;
      first <= 1'b1; recheck <= 1'b0; prev6 <= 1'b0;
      done <= 1'b0; error <= 1'b0;
      id_mfr <= '0; id_dev <= '0;
      fl_addr <= '0; fl_dout <= '0; fl_we_n <= 1'b1; fl_oe_n <= 1'b1;
    end else begin
      done <= 1'b0;
      error <= 1'b0;
      case (st)
        S_IDLE: if (erase_req || id_req) begin
          is_id <= !erase_req;
          idx <= '0; ph <= P_CMD; first <= 1'b1; recheck <= 1'b0;
          fl_addr <= AW'(c_addr); fl_dout <= DW'(c_data);
          fl_we_n <= 1'b0; cnt <= CW'(WE_CYC - 1); st <= S_WR;
        end
        S_WR: if (cnt == '0) begin
          fl_we_n <= 1'b1; st <= S_GAP;
        end else cnt <= cnt - 1'b1;
        S_RD: if (cnt == '0) begin
          fl_oe_n <= 1'b1; st <= S_GAP;
          if (ph == P_IDRD) begin
            if (fl_addr[0]) id_dev <= fl_din;
            else id_mfr <= fl_din;
          end else begin
            prev6 <= fl_din[6];
            first <= 1'b0;
            if (fl_din[7] || (!first && fl_din[6] == prev6)) vd <= V_DONE;
            else if (!first && recheck) vd <= V_FAIL;
            else begin
              vd <= V_CONT;
              if (!first && fl_din[5]) recheck <= 1'b1;
            end
          end
        end else cnt <= cnt - 1'b1;
        default: begin
          case (ph)
            P_CMD: if (last_cmd) begin
              ph <= is_id ? P_IDRD : P_POLL;
              fl_addr <= '0; fl_oe_n <= 1'b0; cnt <= CW'(RD_CYC - 1); st <= S_RD;
            end else begin
              idx <= idx + 3'd1;
              fl_addr <= AW'(c_addr); fl_dout <= DW'(c_data);
              fl_we_n <= 1'b0; cnt <= CW'(WE_CYC - 1); st <= S_WR;
            end
            P_POLL: case (vd)
              V_DONE: begin done <= 1'b1; st <= S_IDLE; end
              V_FAIL: begin
                ph <= P_RST; fl_addr <= '0; fl_dout <= DW'(8'hF0);
                fl_we_n <= 1'b0; cnt <= CW'(WE_CYC - 1); st <= S_WR;
              end
              default: begin
                fl_addr <= '0; fl_oe_n <= 1'b0; cnt <= CW'(RD_CYC - 1); st <= S_RD;
              end
            endcase
            P_IDRD: if (!fl_addr[0]) begin
              fl_addr <= AW'(1); fl_oe_n <= 1'b0; cnt <= CW'(RD_CYC - 1); st <= S_RD;
            end else begin
              ph <= P_RST; fl_addr <= '0; fl_dout <= DW'(8'hF0);
              fl_we_n <= 1'b0; cnt <= CW'(WE_CYC - 1); st <= S_WR;
            end
            default: begin
              st <= S_IDLE;
              if (is_id) done <= 1'b1;
              else error <= 1'b1;
            end
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/nor_erase_seq_chk.sv
module nor_erase_seq_chk #(
  parameter int WE_CYC = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       error,
  input logic       fl_we_n,
  input logic       fl_oe_n,
  input logic [7:0] wdat
);
  logic [15:0] lowc;
  logic [7:0] lastd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lowc <= '0;
      lastd <= '0;
    end else begin
      lowc <= fl_we_n ? 16'd0 : lowc + 16'd1;
      if (!fl_we_n) lastd <= wdat;
    end
  end

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_oe_n));
  assert_we_short_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> lowc < 16'(WE_CYC));
  assert_we_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> lowc == 16'(WE_CYC));
  assert_reset_before_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> lastd == 8'hF0);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_error_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> !error);
  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
  assert_idle_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (fl_we_n && fl_oe_n));
endmodule

bind nor_erase_seq nor_erase_seq_chk #(.WE_CYC(WE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .error(error),
  .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .wdat(fl_dout[7:0])
);

// File: tb/nor_erase_seq_test.sv
`timescale 1ns/1ps
module nor_erase_seq_test;
  localparam int AW = 20, DW = 16, WE_CYC = 3, RD_CYC = 2;
  localparam int NV = 10;
  // {id[31], bit7_ends[30], exp_err[29], 5'b0, ntog[23:16], b5_from[15:8], exp_reads[7:0]}
  localparam logic [31:0] VEC [NV] = '{
    {3'b000, 5'd0, 8'd0,   8'd0, 8'd2},
    {3'b000, 5'd0, 8'd5,   8'd0, 8'd7},
    {3'b010, 5'd0, 8'd3,   8'd0, 8'd4},
    {3'b010, 5'd0, 8'd0,   8'd0, 8'd1},
    {3'b001, 5'd0, 8'd200, 8'd4, 8'd5},
    {3'b000, 5'd0, 8'd3,   8'd4, 8'd5},
    {3'b001, 5'd0, 8'd200, 8'd1, 8'd3},
    {3'b100, 5'd0, 8'd0,   8'd0, 8'd2},
    {3'b000, 5'd0, 8'd1,   8'd0, 8'd3},
    {3'b000, 5'd0, 8'd2,   8'd4, 8'd4}
  };

  logic clk = 0, rst_n = 0, erase_req = 0, id_req = 0;
  logic busy, done, error, fl_we_n, fl_oe_n;
  logic [DW-1:0] id_mfr, id_dev, fl_dout, fl_din;
  logic [AW-1:0] fl_addr;
  int checks = 0, fails = 0;
  int nw, nr, badw, lowc, ndone, nerr;
  int m_ntog, m_b5;
  bit m_b7, oe_prev;
  logic [10:0] wa [16];
  logic [7:0] wd [16];

  always #2 clk = ~clk;

  nor_erase_seq #(.AW(AW), .DW(DW), .WE_CYC(WE_CYC), .RD_CYC(RD_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .erase_req(erase_req), .id_req(id_req),
    .busy(busy), .done(done), .error(error), .id_mfr(id_mfr), .id_dev(id_dev),
    .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_din(fl_din),
    .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n));

  function automatic logic [15:0] status(input int k);
    int s;
    logic [15:0] v;
    s = (k <= m_ntog + 1) ? k : m_ntog + 1;
    v = '0;
    v[6] = s[0];
    v[7] = m_b7 && (k == m_ntog + 1);
    v[5] = (m_b5 != 0) && (k >= m_b5);
    return v;
  endfunction

  function automatic logic [18:0] expw(input bit id, input int i);
    case (i)
      0: return {11'h555, 8'hAA};
      1: return {11'h2AA, 8'h55};
      2: return {11'h555, id ? 8'h90 : 8'h80};
      3: return id ? {11'h000, 8'hF0} : {11'h555, 8'hAA};
      4: return {11'h2AA, 8'h55};
      5: return {11'h555, 8'h10};
      default: return {11'h000, 8'hF0};
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (!fl_we_n) lowc++;
      else if (lowc != 0) begin
        if (lowc != WE_CYC) badw++;
        if (nw < 16) begin wa[nw] = fl_addr[10:0]; wd[nw] = fl_dout[7:0]; end
        nw++;
        lowc = 0;
      end
      if (!fl_oe_n && oe_prev) begin
        nr++;
        if (fl_addr == 20'd0 && nw == 3 && wd[2] == 8'h90) fl_din = 16'h00C2;
        else if (fl_addr == 20'd1) fl_din = 16'h2249;
        else fl_din = status(nr);
      end
      oe_prev = fl_oe_n;
      if (done) ndone++;
      if (error) nerr++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    nw = 0; nr = 0; badw = 0; lowc = 0; ndone = 0; nerr = 0;
  endtask

  task automatic wait_end(output bit ok);
    int t = 0;
    while (ndone == 0 && nerr == 0 && t < 5000) begin @(negedge clk); t++; end
    repeat (8) @(negedge clk);
    ok = (t < 5000);
  endtask

  initial begin
    fl_din = '0; clear_log(); oe_prev = 1;
    m_ntog = 0; m_b5 = 0; m_b7 = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(fl_we_n && fl_oe_n && !busy && !done && !error, "R1",
        {fl_we_n, fl_oe_n, busy, done, error}, 5'b11000);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      bit isid, ok;
      int ew;
      isid = VEC[v][31];
      m_b7 = VEC[v][30];
      m_ntog = VEC[v][23:16];
      m_b5 = VEC[v][15:8];
      clear_log();
      if (isid) id_req = 1; else erase_req = 1;
      @(negedge clk);
      id_req = 0; erase_req = 0;
      wait_end(ok);
      chk(ok, "R4 completion", ok, 1);
      chk(nr == VEC[v][7:0], isid ? "R8 reads" : "R4/R5/R6 reads", nr, VEC[v][7:0]);
      chk(nerr == int'(VEC[v][29]), "R6/R7 error", nerr, VEC[v][29]);
      chk(ndone == int'(!VEC[v][29]), "R9 done pulse", ndone, !VEC[v][29]);
      ew = isid ? 4 : (VEC[v][29] ? 7 : 6);
      chk(nw == ew, isid ? "R8 writes" : "R2/R7 writes", nw, ew);
      for (int i = 0; i < ew && i < nw; i++)
        chk({wa[i], wd[i]} == expw(isid, i), isid ? "R8 sequence" : "R2/R7 sequence",
            {wa[i], wd[i]}, expw(isid, i));
      chk(badw == 0, "R3 we width", badw, 0);
      if (isid) begin
        chk(id_mfr == 16'h00C2, "R8 mfr", id_mfr, 16'h00C2);
        chk(id_dev == 16'h2249, "R8 dev", id_dev, 16'h2249);
      end
    end

    // R10 requests while busy are ignored
    begin
      bit ok;
      m_ntog = 10; m_b5 = 0; m_b7 = 0;
      clear_log();
      erase_req = 1; @(negedge clk); erase_req = 0;
      repeat (5) @(negedge clk);
      id_req = 1; erase_req = 1; @(negedge clk); id_req = 0; erase_req = 0;
      repeat (30) @(negedge clk);
      id_req = 1; @(negedge clk); id_req = 0;
      wait_end(ok);
      repeat (20) @(negedge clk);
      chk(nw == 6, "R10 busy ignore writes", nw, 6);
      chk(nr == 12, "R10 busy ignore reads", nr, 12);
      chk(ndone == 1 && !busy, "R10 single done", ndone, 1);
    end

    // R10 both requests together: erase wins
    begin
      bit ok;
      m_ntog = 0;
      clear_log();
      erase_req = 1; id_req = 1; @(negedge clk); erase_req = 0; id_req = 0;
      wait_end(ok);
      chk(nw == 6 && wd[2] == 8'h80, "R10 priority", wd[2], 8'h80);
      chk(nr == 2, "R10 priority reads", nr, 2);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule